// File: doc/BRIEF.md
# Interrupt Request Front-End Controller

This block sits between sixteen external interrupt request lines and a CPU. For every line it picks one of two physical pins (bank A or bank B), brings that pin into the clock domain through a two-flop synchronizer, and detects the programmed edge on it. The edge sets a sticky per-line flag. Flagged lines whose enable bit is set compete for one maskable request to the CPU, and the lowest line index wins. A separate non-maskable pin produces its own request. Both requests are held until the CPU returns an acknowledge pulse.

Acceptance of a new request is gated in three ways. The CPU's mask-update strobe closes the gate for a fixed lock-out window. An input that marks a non-interruptible transfer holds the gate shut for as long as it stays high. The acting mask bit blocks maskable requests only. Software configures the block and clears flags over a simple register bus with a registered read port.

Top module: `irq_front_ctrl`

## Requirements
- R1: After synchronous reset, `req_valid_o`, `nmi_req_o` and `bus_rdata_o` are 0, and every register reads back 0.
- R2: A selected pin level change first sampled at clock edge k sets that line's flag at edge k+2. If nothing blocks it, `req_valid_o` rises at edge k+3.
- R3: Line n has a 2-bit edge-sense field. For n<8 it sits at bits 2n+1:2n of address 3; for n>=8 it sits at bits 2(n-8)+1:2(n-8) of address 4. Codes: 00 rising, 01 falling, 10 or 11 both. A transition the field does not select leaves the flag clear.
- R4: Bit n of address 2 selects the pin for line n (0 = `pin_a_i[n]`, 1 = `pin_b_i[n]`). Changing the selection to a pin at a different level counts as an edge of the new level, so a rising-sense line flags one edge after the write.
- R5: Flags read at address 1. A flag stays set until a write to address 1 carries 0 in its bit, and that write only clears the flag if the flag was read as 1 since it was last set. Writing 1 has no effect.
- R6: If a clearing write and a new edge on the same line fall in the same cycle, the flag stays set.
- R7: Bit n of address 0 enables line n. A disabled line still sets its flag but raises no request. Enabling it later raises the request one edge after the write edge.
- R8: Among enabled flagged lines the lowest index is presented on `req_id_o` with `req_valid_o`. Both stay stable until an `ack_i` pulse, which drops `req_valid_o` at that edge.
- R9: If `mask_wr_i` is sampled at edge w, neither `req_valid_o` nor `nmi_req_o` rises at edges w through w+3. A request pending all along rises at edge w+4.
- R10: `mask_val_i` sampled with `mask_wr_i` becomes the acting mask two edges after the write edge. While it is 1, `req_valid_o` never rises. `nmi_req_o` is unaffected by the mask.
- R11: While `xfer_busy_i` is 1, neither request rises. A request pending during the transfer is raised once the input is 0 and nothing else blocks it.
- R12: A rising edge on `nmi_i` sampled at edge k raises `nmi_req_o` at edge k+3 if nothing blocks it. The request holds until an `nmi_ack_i` pulse, which clears it.
- R13: A read at edge r updates `bus_rdata_o` at edge r and holds it until the next read. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_a_i | input | 16 | Bank A request pins, asynchronous |
| pin_b_i | input | 16 | Bank B request pins, asynchronous |
| nmi_i | input | 1 | Non-maskable request pin, asynchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| mask_wr_i | input | 1 | CPU mask-update strobe |
| mask_val_i | input | 1 | New mask value, 1 blocks maskable requests |
| xfer_busy_i | input | 1 | Non-interruptible transfer in progress |
| ack_i | input | 1 | Acknowledge pulse for the maskable request |
| nmi_ack_i | input | 1 | Acknowledge pulse for the non-maskable request |
| req_valid_o | output | 1 | Maskable request valid |
| req_id_o | output | 4 | Index of the winning line |
| nmi_req_o | output | 1 | Non-maskable request |

## Verification
The hardest case to reach is the collision in R6. The pin change has to leave the second synchronizer flop in exactly the cycle where the clearing write is sampled, and the flag must already have been read as 1. The stimulus first sets and reads the flag on a both-edges line. It then toggles the pin at a falling clock edge, counts two rising edges, and issues the write, so the write lands on the edge that registers the new flag. The lock-out window is reached the same way: a request is held pending behind the transfer input, and the transfer input drops in the same cycle as the mask strobe, so the gap before the rise can only come from the lock-out.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;

    localparam int NUM_LINES   = 16;
    localparam int ID_W        = $clog2(NUM_LINES);
    localparam int DATA_W      = NUM_LINES;
    localparam int ADDR_W      = 3;
    localparam int SENSE_W     = 2;
    localparam int SYNC_STAGES = 2;
    localparam int LOCK_STATES = 3;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_RISE     = 2'b00,
        SENSE_FALL     = 2'b01,
        SENSE_BOTH     = 2'b10,
        SENSE_BOTH_ALT = 2'b11
    } sense_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE   = 3'd0,
        REG_FLAGS    = 3'd1,
        REG_BANK     = 3'd2,
        REG_SENSE_LO = 3'd3,
        REG_SENSE_HI = 3'd4
    } reg_addr_e;

    // Per-line configuration carried into each edge detector
    typedef struct packed {
        logic   bank;
        sense_e sense;
    } line_cfg_t;

    // Returns 1 when the transition prev->cur matches the programmed sense
    function automatic logic edge_hit(input sense_e s, input logic prev, input logic cur);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        case (s)
            SENSE_RISE: edge_hit = rise;
            SENSE_FALL: edge_hit = fall;
            default:    edge_hit = rise | fall;
        endcase
    endfunction

    // Lowest set bit index; 0 when the vector is empty
    function automatic logic [ID_W-1:0] lowest_set(input logic [NUM_LINES-1:0] v);
        lowest_set = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (v[i]) lowest_set = ID_W'(i);
        end
    endfunction

endpackage

// File: rtl/irq_fe_sync.sv
module irq_fe_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_fe_line.sv
module irq_fe_line
    import irq_fe_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      pin_a_i,
    input  logic      pin_b_i,
    input  line_cfg_t cfg_i,
    input  logic      rd_mark_i,
    input  logic      clr_wr_i,
    output logic      flag_o
);
    logic level;
    logic prev_q;
    logic edge_det;
    logic seen_q;
    logic flag_q;
    logic clear_ok;

    // Selection happens after synchronization, so a select change is itself a level change
    assign level    = cfg_i.bank ? pin_b_i : pin_a_i;
    assign edge_det = edge_hit(cfg_i.sense, prev_q, level);
    assign clear_ok = clr_wr_i & seen_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            prev_q <= level;
            if (edge_det)      flag_q <= 1'b1;
            else if (clear_ok) flag_q <= 1'b0;
            if (clear_ok)                 seen_q <= 1'b0;
            else if (rd_mark_i && flag_q) seen_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    assert_sticky_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (flag_q && !clr_wr_i) |=> flag_q);

    assert_unread_keeps_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (flag_q && !seen_q && !rd_mark_i) |=> flag_q);

    assert_edge_wins_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        edge_det |=> flag_q);

endmodule

// File: rtl/irq_fe_grant.sv
module irq_fe_grant
    import irq_fe_pkg::*;
#(
    parameter int LOCK_LEN = LOCK_STATES
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NUM_LINES-1:0] flags_i,
    input  logic [NUM_LINES-1:0] enable_i,
    input  logic                 mask_wr_i,
    input  logic                 mask_val_i,
    input  logic                 xfer_busy_i,
    input  logic                 ack_i,
    input  logic                 nmi_edge_i,
    input  logic                 nmi_ack_i,
    output logic                 req_valid_o,
    output logic [ID_W-1:0]      req_id_o,
    output logic                 nmi_req_o
);
    localparam int LOCK_W = $clog2(LOCK_LEN + 1);

    logic [LOCK_W-1:0]    lock_cnt_q;
    logic                 mask_p1_vld_q, mask_p1_val_q;
    logic                 mask_p2_vld_q, mask_p2_val_q;
    logic                 mask_eff_q;
    logic                 req_valid_q;
    logic [ID_W-1:0]      req_id_q;
    logic                 nmi_pend_q;
    logic                 nmi_req_q;
    logic [NUM_LINES-1:0] pend;
    logic                 gate_open;

    assign pend      = flags_i & enable_i;
    assign gate_open = (lock_cnt_q == '0) && !mask_wr_i && !xfer_busy_i;

    // Lock-out counter and two-stage mask pipeline
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lock_cnt_q    <= '0;
            mask_p1_vld_q <= 1'b0;
            mask_p1_val_q <= 1'b0;
            mask_p2_vld_q <= 1'b0;
            mask_p2_val_q <= 1'b0;
            mask_eff_q    <= 1'b0;
        end else begin
            if (mask_wr_i)              lock_cnt_q <= LOCK_W'(LOCK_LEN);
            else if (lock_cnt_q != '0)  lock_cnt_q <= lock_cnt_q - 1'b1;
            mask_p1_vld_q <= mask_wr_i;
            mask_p1_val_q <= mask_val_i;
            mask_p2_vld_q <= mask_p1_vld_q;
            mask_p2_val_q <= mask_p1_val_q;
            if (mask_p2_vld_q) mask_eff_q <= mask_p2_val_q;
        end
    end

    // Maskable request: raised through the gate, frozen until acknowledge
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_valid_q <= 1'b0;
            req_id_q    <= '0;
        end else if (req_valid_q) begin
            if (ack_i) req_valid_q <= 1'b0;
        end else if (gate_open && !mask_eff_q && (pend != '0)) begin
            req_valid_q <= 1'b1;
            req_id_q    <= lowest_set(pend);
        end
    end

    // Non-maskable request: pending latch plus handshake
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            nmi_pend_q <= 1'b0;
            nmi_req_q  <= 1'b0;
        end else if (nmi_req_q && nmi_ack_i) begin
            nmi_req_q  <= 1'b0;
            nmi_pend_q <= nmi_edge_i;
        end else begin
            if (nmi_edge_i) nmi_pend_q <= 1'b1;
            if (!nmi_req_q && nmi_pend_q && gate_open) nmi_req_q <= 1'b1;
        end
    end

    assign req_valid_o = req_valid_q;
    assign req_id_o    = req_id_q;
    assign nmi_req_o   = nmi_req_q;

    assert_lock_req_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(req_valid_q) |-> ($past(lock_cnt_q) == '0 && !$past(mask_wr_i)));

    assert_lock_nmi_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(nmi_req_q) |-> ($past(lock_cnt_q) == '0 && !$past(mask_wr_i)));

    assert_mask_blocks_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(req_valid_q) |-> !$past(mask_eff_q));

    assert_xfer_req_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(req_valid_q) |-> !$past(xfer_busy_i));

    assert_xfer_nmi_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(nmi_req_q) |-> !$past(xfer_busy_i));

    assert_needs_enable_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(req_valid_q) |-> ($past(pend) != '0));

    assert_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_q && !ack_i) |=> (req_valid_q && $stable(req_id_q)));

    assert_nmi_hold_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        (nmi_req_q && !nmi_ack_i) |=> nmi_req_q);

endmodule

// File: rtl/irq_front_ctrl.sv
module irq_front_ctrl
    import irq_fe_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NUM_LINES-1:0] pin_a_i,
    input  logic [NUM_LINES-1:0] pin_b_i,
    input  logic                 nmi_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    input  logic                 mask_wr_i,
    input  logic                 mask_val_i,
    input  logic                 xfer_busy_i,
    input  logic                 ack_i,
    input  logic                 nmi_ack_i,
    output logic                 req_valid_o,
    output logic [ID_W-1:0]      req_id_o,
    output logic                 nmi_req_o
);
    localparam int SYNC_W  = 2 * NUM_LINES + 1;
    localparam int SENSE_T = SENSE_W * NUM_LINES;

    logic [SYNC_W-1:0]    sync_bus;
    logic [NUM_LINES-1:0] sync_a;
    logic [NUM_LINES-1:0] sync_b;
    logic                 sync_nmi;
    logic                 nmi_prev_q;
    logic                 nmi_edge;

    logic [NUM_LINES-1:0] enable_q;
    logic [NUM_LINES-1:0] bank_q;
    logic [SENSE_T-1:0]   sense_q;
    logic [NUM_LINES-1:0] flags;
    logic [NUM_LINES-1:0] clr_wr;
    logic                 rd_mark;
    logic [DATA_W-1:0]    rdata_q;

    irq_fe_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i ({nmi_i, pin_b_i, pin_a_i}),
        .sync_o  (sync_bus)
    );

    assign sync_a   = sync_bus[NUM_LINES-1:0];
    assign sync_b   = sync_bus[2*NUM_LINES-1:NUM_LINES];
    assign sync_nmi = sync_bus[SYNC_W-1];

    always_ff @(posedge clk_i) begin
        if (rst_i) nmi_prev_q <= 1'b0;
        else       nmi_prev_q <= sync_nmi;
    end
    assign nmi_edge = sync_nmi & ~nmi_prev_q;

    // Configuration registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            enable_q <= '0;
            bank_q   <= '0;
            sense_q  <= '0;
        end else if (bus_wr_i) begin
            case (bus_addr_i)
                REG_ENABLE:   enable_q                  <= bus_wdata_i;
                REG_BANK:     bank_q                    <= bus_wdata_i;
                REG_SENSE_LO: sense_q[DATA_W-1:0]       <= bus_wdata_i;
                REG_SENSE_HI: sense_q[SENSE_T-1:DATA_W] <= bus_wdata_i;
                default:      ;
            endcase
        end
    end

    assign rd_mark = bus_rd_i && (bus_addr_i == REG_FLAGS);
    assign clr_wr  = (bus_wr_i && (bus_addr_i == REG_FLAGS)) ? ~bus_wdata_i : '0;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        line_cfg_t cfg;
        assign cfg.bank  = bank_q[n];
        assign cfg.sense = sense_e'(sense_q[SENSE_W*n +: SENSE_W]);

        irq_fe_line u_line (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .pin_a_i   (sync_a[n]),
            .pin_b_i   (sync_b[n]),
            .cfg_i     (cfg),
            .rd_mark_i (rd_mark),
            .clr_wr_i  (clr_wr[n]),
            .flag_o    (flags[n])
        );
    end

    irq_fe_grant #(.LOCK_LEN(LOCK_STATES)) u_grant (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .flags_i     (flags),
        .enable_i    (enable_q),
        .mask_wr_i   (mask_wr_i),
        .mask_val_i  (mask_val_i),
        .xfer_busy_i (xfer_busy_i),
        .ack_i       (ack_i),
        .nmi_edge_i  (nmi_edge),
        .nmi_ack_i   (nmi_ack_i),
        .req_valid_o (req_valid_o),
        .req_id_o    (req_id_o),
        .nmi_req_o   (nmi_req_o)
    );

    // Registered read port
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_q <= '0;
        end else if (bus_rd_i) begin
            case (bus_addr_i)
                REG_ENABLE:   rdata_q <= enable_q;
                REG_FLAGS:    rdata_q <= flags;
                REG_BANK:     rdata_q <= bank_q;
                REG_SENSE_LO: rdata_q <= sense_q[DATA_W-1:0];
                REG_SENSE_HI: rdata_q <= sense_q[SENSE_T-1:DATA_W];
                default:      rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata_o = rdata_q;

    assert_rdata_hold_R13: assert property (@(posedge clk_i) disable iff (rst_i)
        !bus_rd_i |=> $stable(bus_rdata_o));

    assert_unmapped_zero_R13: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_rd_i && bus_addr_i > REG_SENSE_HI) |=> (bus_rdata_o == '0));

    assert_flag_read_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_mark |=> (bus_rdata_o == $past(flags)));

endmodule

// File: tb/irq_front_ctrl_bench.sv
module irq_front_ctrl_bench;
    import irq_fe_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NUM_LINES-1:0] pin_a = '0;
    logic [NUM_LINES-1:0] pin_b = '0;
    logic                 nmi = 1'b0;
    logic                 bus_wr = 1'b0;
    logic                 bus_rd = 1'b0;
    logic [ADDR_W-1:0]    bus_addr = '0;
    logic [DATA_W-1:0]    bus_wdata = '0;
    logic [DATA_W-1:0]    bus_rdata;
    logic                 mask_wr = 1'b0;
    logic                 mask_val = 1'b0;
    logic                 xfer_busy = 1'b0;
    logic                 ack = 1'b0;
    logic                 nmi_ack = 1'b0;
    logic                 req_valid;
    logic [ID_W-1:0]      req_id;
    logic                 nmi_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_front_ctrl u_irq_front_ctrl (
        .clk_i(clk), .rst_i(rst), .pin_a_i(pin_a), .pin_b_i(pin_b), .nmi_i(nmi),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .mask_wr_i(mask_wr), .mask_val_i(mask_val), .xfer_busy_i(xfer_busy),
        .ack_i(ack), .nmi_ack_i(nmi_ack),
        .req_valid_o(req_valid), .req_id_o(req_id), .nmi_req_o(nmi_req)
    );

    task automatic check(input string tag, input logic [31:0] actual, input logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, actual, expected);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_req(input int id);
        exp_q.push_back(id);
    endtask

    // Handler order: read flags, clear the pending bits, acknowledge
    task automatic service(input logic [DATA_W-1:0] exp_flags, input string tag);
        logic [DATA_W-1:0] rd;
        bus_read(REG_FLAGS, rd);
        check(tag, rd, exp_flags);
        bus_write(REG_FLAGS, ~exp_flags);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check("R8 ack drops request", req_valid, 0);
        bus_read(REG_FLAGS, rd);
        check("R5 flag cleared after read", rd & exp_flags, 0);
    endtask

    task automatic mask_pulse(input logic v);
        mask_wr = 1'b1; mask_val = v;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    // Scoreboard monitor: every new request is compared with the next expected id
    initial begin : monitor
        logic prev_valid;
        prev_valid = 1'b0;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev_valid = 1'b0;
            end else begin
                if (req_valid && !prev_valid) begin
                    if (exp_q.size() == 0) check("R8 unexpected request", 32'(req_id), 32'hFFFF);
                    else                   check("R8 winner id", 32'(req_id), 32'(exp_q.pop_front()));
                end
                prev_valid = req_valid;
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [DATA_W-1:0] rd;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        check("R1 req_valid after reset", req_valid, 0);
        check("R1 nmi_req after reset", nmi_req, 0);
        check("R1 rdata after reset", bus_rdata, 0);
        bus_read(REG_FLAGS, rd);  check("R1 flags reset", rd, 0);
        bus_read(REG_ENABLE, rd); check("R1 enable reset", rd, 0);

        // R13 readback and unmapped address
        bus_write(REG_ENABLE, 16'hFFFF);
        bus_read(REG_ENABLE, rd); check("R13 enable readback", rd, 16'hFFFF);
        bus_read(3'd6, rd);       check("R13 unmapped reads zero", rd, 0);
        tick(2);
        check("R13 rdata holds without read", bus_rdata, 0);

        // R2 latency: rising edge on line 3
        pin_a[3] = 1'b1; expect_req(3);
        tick(3); check("R2 no request at k+2", req_valid, 0);
        tick(1); check("R2 request at k+3", req_valid, 1);
        service(16'h0008, "R2 flag line 3");

        // R3 falling sense on line 5 ignores a rising edge
        bus_write(REG_SENSE_LO, 16'h0400);
        pin_a[5] = 1'b1;
        tick(5); check("R3 rising ignored under falling sense", req_valid, 0);
        bus_read(REG_FLAGS, rd); check("R3 no flag on unselected edge", rd, 0);
        pin_a[5] = 1'b0; expect_req(5);
        tick(4); check("R3 falling edge requests", req_valid, 1);
        service(16'h0020, "R3 flag line 5");

        // R3 both-edges sense on line 10
        bus_write(REG_SENSE_HI, 16'h0020);
        pin_a[10] = 1'b1; expect_req(10);
        tick(4); check("R3 both: rise", req_valid, 1);
        service(16'h0400, "R3 flag line 10 rise");
        pin_a[10] = 1'b0; expect_req(10);
        tick(4); check("R3 both: fall", req_valid, 1);
        service(16'h0400, "R3 flag line 10 fall");

        // R8 priority and hold
        pin_a[9] = 1'b1; pin_a[2] = 1'b1; expect_req(2);
        tick(4); check("R8 lowest index wins", 32'(req_id), 2);
        tick(3); check("R8 request held", req_valid, 1);
        check("R8 id held", 32'(req_id), 2);
        bus_read(REG_FLAGS, rd); check("R8 both flags set", rd, 16'h0204);
        bus_write(REG_FLAGS, ~16'h0004);
        expect_req(9);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        tick(1); check("R8 next winner after ack", req_valid, 1);
        check("R8 next id", 32'(req_id), 9);
        service(16'h0200, "R8 flag line 9");

        // R7 disabled line flags but does not request
        bus_write(REG_ENABLE, 16'hFFBF);
        pin_a[6] = 1'b1;
        tick(6); check("R7 disabled line no request", req_valid, 0);
        bus_read(REG_FLAGS, rd); check("R7 disabled line still flags", rd, 16'h0040);
        expect_req(6);
        bus_write(REG_ENABLE, 16'hFFFF);
        tick(1); check("R7 request one edge after enable", req_valid, 1);
        service(16'h0040, "R7 flag line 6");

        // R5 clear needs a prior read; writing 1 does nothing
        bus_write(REG_ENABLE, 16'hEFFF);
        pin_a[12] = 1'b1;
        tick(4);
        bus_write(REG_FLAGS, 16'h0000);
        bus_read(REG_FLAGS, rd);  check("R5 unread flag survives write 0", rd, 16'h1000);
        bus_write(REG_FLAGS, 16'hFFFF);
        bus_read(REG_FLAGS, rd);  check("R5 write 1 no effect", rd, 16'h1000);
        bus_write(REG_FLAGS, 16'h0000);
        bus_read(REG_FLAGS, rd);  check("R5 read then write 0 clears", rd, 0);

        // R6 clearing write collides with a new edge
        bus_write(REG_SENSE_HI, 16'h0220);
        pin_a[12] = 1'b0;
        tick(4);
        bus_read(REG_FLAGS, rd);  check("R6 setup flag", rd, 16'h1000);
        pin_a[12] = 1'b1;
        tick(2);
        bus_write(REG_FLAGS, 16'h0000);
        bus_read(REG_FLAGS, rd);  check("R6 edge beats clear", rd, 16'h1000);
        bus_write(REG_FLAGS, 16'h0000);
        bus_read(REG_FLAGS, rd);  check("R6 cleanup clear", rd, 0);

        // R4 selection change creates an edge
        pin_b[7] = 1'b1;
        tick(4); check("R4 unselected pin ignored", req_valid, 0);
        bus_read(REG_FLAGS, rd);  check("R4 no flag before select", rd, 0);
        expect_req(7);
        bus_write(REG_BANK, 16'h0080);
        tick(1); check("R4 no request before flag", req_valid, 0);
        tick(1); check("R4 internal edge requests", req_valid, 1);
        service(16'h0080, "R4 flag line 7");
        bus_read(REG_BANK, rd);   check("R13 bank readback", rd, 16'h0080);

        // R11 transfer holds both; R9 lock-out on release
        bus_write(REG_ENABLE, 16'hFFFF);
        xfer_busy = 1'b1;
        pin_a[1] = 1'b1; nmi = 1'b1;
        tick(8);
        check("R11 maskable blocked by transfer", req_valid, 0);
        check("R11 nmi blocked by transfer", nmi_req, 0);
        expect_req(1);
        xfer_busy = 1'b0; mask_wr = 1'b1; mask_val = 1'b0;
        @(negedge clk); mask_wr = 1'b0;
        check("R9 blocked at w", req_valid, 0);
        tick(1); check("R9 blocked at w+1", req_valid, 0);
        tick(1); check("R9 blocked at w+2", req_valid, 0);
        tick(1); check("R9 blocked at w+3", req_valid, 0);
        check("R9 nmi blocked at w+3", nmi_req, 0);
        tick(1); check("R9 maskable rises at w+4", req_valid, 1);
        check("R11 nmi accepted after transfer", nmi_req, 1);
        tick(3); check("R12 nmi held", nmi_req, 1);
        nmi_ack = 1'b1; @(negedge clk); nmi_ack = 1'b0;
        check("R12 nmi cleared by ack", nmi_req, 0);
        tick(2); check("R12 nmi stays clear", nmi_req, 0);
        service(16'h0002, "R11 flag line 1");
        nmi = 1'b0;

        // R10 mask blocks maskable only
        mask_pulse(1'b1);
        tick(6);
        pin_a[4] = 1'b1;
        tick(8); check("R10 masked request stays low", req_valid, 0);
        bus_read(REG_FLAGS, rd);  check("R10 flag pending under mask", rd, 16'h0010);
        nmi = 1'b1;
        tick(3); check("R12 nmi not yet at k+2", nmi_req, 0);
        tick(1); check("R10 nmi ignores mask", nmi_req, 1);
        nmi_ack = 1'b1; @(negedge clk); nmi_ack = 1'b0;
        check("R12 nmi ack", nmi_req, 0);
        expect_req(4);
        mask_pulse(1'b0);
        tick(3); check("R10 unmask still locked at w+3", req_valid, 0);
        tick(1); check("R10 unmasked request at w+4", req_valid, 1);
        service(16'h0010, "R10 flag line 4");

        check("R8 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule